// File: doc/BRIEF.md
# HDLC Frame Receiver with Selectable FCS

This block receives one HDLC channel a bit at a time. A bit is taken on each clock cycle in which `bit_en` is high. The block looks for flag octets (0x7E) and removes the zero that the sender inserts after five ones. It packs the payload into bytes, least significant bit first, and checks a frame check sequence of 16 or 32 bits. Bytes leave on a valid/last stream. Every frame, including aborted and too-short ones, ends with a one-cycle status pulse that carries the abort, short-frame and CRC-error flags. Three event pulses, each with its own mask input, report these conditions:

- a frame has finished;
- a frame was too short to deliver;
- the idle pattern between frames has changed between repeated flags and continuous ones.

Received bytes are held back in a small buffer. This lets the block strip the FCS bytes, or pass them on, and mark the true last byte. The buffer holds the FCS length plus one byte. The frame-level state machine has five states:

- `ST_HUNT`: no flag seen since reset or since the last abort. A flag moves to `ST_OPEN`.
- `ST_OPEN`: a flag has been seen and no frame bit has arrived yet. A further flag stays here. An abort returns to `ST_HUNT` and produces no status. The first data bit moves to `ST_DATA`.
- `ST_DATA`: frame bits are arriving.
  - A closing flag moves to `ST_FLUSH`, or to `ST_STAT` if the frame is too short.
  - An abort moves to `ST_STAT`.
- `ST_FLUSH`: the held bytes are emitted, one per cycle, then the state moves to `ST_STAT`.
- `ST_STAT`: the status pulse is emitted. The state then moves to `ST_OPEN`, because the closing flag also opens the next frame. After an abort it moves to `ST_HUNT`.

Top module: `hdlc_rx`

## Requirements
- R1: Inside a frame, a zero that follows five consecutive ones is deleted. The bytes delivered equal the payload the sender stuffed, each byte assembled least significant bit first.
- R2: With `crc32_sel`=0, the FCS is two bytes of the reflected CRC-16 (x^16+x^12+x^5+1). The register is preset to all ones, and a frame is good when the reflected residue is 0xF0B8.
- R3: With `crc32_sel`=1, the FCS is four bytes of the reflected standard 32-bit CRC, preset to all ones, with good residue 0xDEBB20E3.
- R4: With `fcs_pass`=0 the FCS bytes are removed and `byte_last` marks the final payload byte. With `fcs_pass`=1 the FCS bytes follow the payload and the last FCS byte carries `byte_last`. The status pulse comes in the cycle after the last byte. Mode inputs are latched at a frame's first bit.
- R5: A frame whose FCS does not match ends with `stat_crc_err`=1, whatever the `fcs_pass` setting.
- R6: Seven consecutive ones inside a frame abort it. Bytes still held are discarded. Bytes already sent keep `byte_last`=0. The status shows `stat_abort`=1 with the short and CRC flags at 0.
- R7: A flag-ended frame with fewer complete bytes than the FCS length plus one delivers no bytes. Its status shows `stat_short`=1, `stat_crc_err`=0, and `ev_short` is raised.
- R8: A frame that is long enough but whose bit count is not a multiple of 8 delivers its complete payload bytes. The trailing partial byte is dropped. Its status has `stat_short`=1 and `stat_crc_err`=0, and `ev_short` stays low.
- R9: `ev_fin` pulses together with every status pulse, and at no other time.
- R10: `ev_fill` pulses whenever the detected line-fill state changes between flags and continuous ones (seven ones). The fill state is "ones" after reset.
- R11: Each mask input, when high, suppresses only its own event (`mask_fin` for `ev_fin`, `mask_short` for `ev_short`, `mask_fill` for `ev_fill`). The data stream and status are unaffected.
- R12: After reset all outputs are 0. The status flags are 0 outside the status pulse, and `byte_valid` and `stat_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial line bit |
| crc32_sel | input | 1 | 0: 16-bit FCS, 1: 32-bit FCS |
| fcs_pass | input | 1 | 1: deliver FCS bytes as data |
| mask_fin | input | 1 | Suppresses `ev_fin` |
| mask_short | input | 1 | Suppresses `ev_short` |
| mask_fill | input | 1 | Suppresses `ev_fill` |
| byte_valid | output | 1 | Received byte present |
| byte_data | output | 8 | Received byte |
| byte_last | output | 1 | Final delivered byte of the frame |
| stat_valid | output | 1 | End-of-frame status pulse |
| stat_abort | output | 1 | Frame ended by abort |
| stat_short | output | 1 | Frame too short or not octet aligned |
| stat_crc_err | output | 1 | FCS mismatch |
| ev_fin | output | 1 | Frame-finished event |
| ev_short | output | 1 | Too-short-frame event |
| ev_fill | output | 1 | Idle fill changed |

## Verification
A line bit can only become a data bit once seven later bits have been seen, because the deframer holds the last seven destuffed bits while it waits to see whether they form a flag. Bytes therefore appear a variable number of cycles after the bits that carry them. For that reason the bench queues the expected bytes and statuses in order and compares them as they appear, rather than at fixed cycles. The fixed latencies are checked by properties:

- the status pulse falls exactly one cycle after the byte that carries `byte_last`;
- each event pulse coincides with its status pulse or depends on the mask value one cycle earlier.

Event counts are compared only after the line has been idle long enough for every pending result to drain.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
    typedef enum logic [2:0] {
        ST_HUNT,
        ST_OPEN,
        ST_DATA,
        ST_FLUSH,
        ST_STAT
    } rx_state_t;

    localparam int FCS16_BYTES = 2;
    localparam int FCS32_BYTES = 4;

    localparam logic [15:0] POLY16 = 16'h8408;
    localparam logic [15:0] RES16  = 16'hF0B8;
    localparam logic [31:0] POLY32 = 32'hEDB88320;
    localparam logic [31:0] RES32  = 32'hDEBB20E3;

    // Ones in a row that end a flag; one more is an abort.
    localparam int FLAG_ONES  = 6;
    localparam int STUFF_ONES = 5;
endpackage

// File: rtl/hdlc_rx_deframe.sv
module hdlc_rx_deframe
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic d_valid,
    output logic d_bit,
    output logic flag_hit,
    output logic abort_hit,
    output logic fill_chg
);
    // Destuffed bits are held back until it is known they are not a flag.
    localparam int HOLD = FLAG_ONES + 1;
    localparam int PW   = $clog2(HOLD + 1);

    logic [2:0]      ones;
    logic [HOLD-1:0] pipe;
    logic [PW-1:0]   pcnt;
    logic            synced;
    logic            fill_ones;
    logic            push;

    always_comb begin
        push = 1'b0;
        if (bit_en) begin
            if (bit_in) push = (ones < 3'(FLAG_ONES));
            else        push = (ones != 3'(STUFF_ONES)) && (ones != 3'(FLAG_ONES));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones      <= '0;
            pipe      <= '0;
            pcnt      <= '0;
            synced    <= 1'b0;
            fill_ones <= 1'b1;
            d_valid   <= 1'b0;
            d_bit     <= 1'b0;
            flag_hit  <= 1'b0;
            abort_hit <= 1'b0;
            fill_chg  <= 1'b0;
        end else begin
            d_valid   <= 1'b0;
            flag_hit  <= 1'b0;
            abort_hit <= 1'b0;
            fill_chg  <= 1'b0;
            if (bit_en) begin
                if (bit_in) begin
                    if (ones == 3'(FLAG_ONES)) begin
                        abort_hit <= 1'b1;
                        synced    <= 1'b0;
                        pcnt      <= '0;
                        if (!fill_ones) begin
                            fill_ones <= 1'b1;
                            fill_chg  <= 1'b1;
                        end
                    end
                    if (ones != 3'd7) ones <= ones + 3'd1;
                end else begin
                    ones <= '0;
                    if (ones == 3'(FLAG_ONES)) begin
                        flag_hit <= 1'b1;
                        synced   <= 1'b1;
                        pcnt     <= '0;
                        if (fill_ones) begin
                            fill_ones <= 1'b0;
                            fill_chg  <= 1'b1;
                        end
                    end
                end
                if (push) begin
                    pipe <= {pipe[HOLD-2:0], bit_in};
                    if (pcnt == PW'(HOLD)) begin
                        d_valid <= synced;
                        d_bit   <= pipe[HOLD-1];
                    end else begin
                        pcnt <= pcnt + PW'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   POLY = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] crc
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) crc <= '1;
        else if (en)       crc <= (crc >> 1) ^ ((crc[0] ^ din) ? POLY : '0);
    end
endmodule

// File: rtl/hdlc_rx.sv
module hdlc_rx
    import hdlc_rx_pkg::*;
#(
    parameter int MAXFCS = FCS32_BYTES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       bit_in,
    input  logic       crc32_sel,
    input  logic       fcs_pass,
    input  logic       mask_fin,
    input  logic       mask_short,
    input  logic       mask_fill,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       byte_last,
    output logic       stat_valid,
    output logic       stat_abort,
    output logic       stat_short,
    output logic       stat_crc_err,
    output logic       ev_fin,
    output logic       ev_short,
    output logic       ev_fill
);
    localparam int DEPTH = MAXFCS + 1;
    localparam int CW    = $clog2(DEPTH + 1);

    logic        d_valid, d_bit, flag_hit, abort_hit, fill_chg;
    logic [15:0] crc16;
    logic [31:0] crc32;

    hdlc_rx_deframe u_deframe (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .d_valid(d_valid), .d_bit(d_bit), .flag_hit(flag_hit),
        .abort_hit(abort_hit), .fill_chg(fill_chg)
    );

    hdlc_rx_crc #(.W(16), .POLY(POLY16)) u_crc16 (
        .clk(clk), .rst_n(rst_n), .clr(flag_hit), .en(d_valid),
        .din(d_bit), .crc(crc16)
    );

    hdlc_rx_crc #(.W(32), .POLY(POLY32)) u_crc32 (
        .clk(clk), .rst_n(rst_n), .clr(flag_hit), .en(d_valid),
        .din(d_bit), .crc(crc32)
    );

    rx_state_t     state, nxt;
    logic          cfg32, cfgpass;
    logic [2:0]    bitcnt;
    logic [7:0]    shreg;
    logic [7:0]    fifo [DEPTH];
    logic [CW-1:0] bcnt, flush_n, hold;
    logic          r_abort, r_short, r_crc, r_evshort;
    logic [7:0]    byte_n;
    logic          end_short, end_mis, crc_ok, in_rx;

    assign hold      = cfg32 ? CW'(FCS32_BYTES + 1) : CW'(FCS16_BYTES + 1);
    assign byte_n    = {d_bit, shreg[7:1]};
    assign end_short = (bcnt < hold);
    assign end_mis   = (bitcnt != 3'd0);
    assign crc_ok    = cfg32 ? (crc32 == RES32) : (crc16 == RES16);
    assign in_rx     = (state == ST_OPEN) || (state == ST_DATA);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT:  if (flag_hit) nxt = ST_OPEN;
            ST_OPEN:  begin
                if (abort_hit)    nxt = ST_HUNT;
                else if (d_valid) nxt = ST_DATA;
            end
            ST_DATA:  begin
                if (abort_hit)     nxt = ST_STAT;
                else if (flag_hit) nxt = end_short ? ST_STAT : ST_FLUSH;
            end
            ST_FLUSH: if (flush_n == CW'(1)) nxt = ST_STAT;
            ST_STAT:  nxt = r_abort ? ST_HUNT : ST_OPEN;
            default:  nxt = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg32        <= 1'b0;
            cfgpass      <= 1'b0;
            bitcnt       <= '0;
            shreg        <= '0;
            bcnt         <= '0;
            flush_n      <= '0;
            r_abort      <= 1'b0;
            r_short      <= 1'b0;
            r_crc        <= 1'b0;
            r_evshort    <= 1'b0;
            for (int i = 0; i < DEPTH; i++) fifo[i] <= '0;
            byte_valid   <= 1'b0;
            byte_data    <= '0;
            byte_last    <= 1'b0;
            stat_valid   <= 1'b0;
            stat_abort   <= 1'b0;
            stat_short   <= 1'b0;
            stat_crc_err <= 1'b0;
            ev_fin       <= 1'b0;
            ev_short     <= 1'b0;
            ev_fill      <= 1'b0;
        end else begin
            byte_valid   <= 1'b0;
            byte_last    <= 1'b0;
            stat_valid   <= 1'b0;
            stat_abort   <= 1'b0;
            stat_short   <= 1'b0;
            stat_crc_err <= 1'b0;
            ev_fin       <= 1'b0;
            ev_short     <= 1'b0;
            ev_fill      <= fill_chg & ~mask_fill;

            if (in_rx && d_valid) begin
                if (state == ST_OPEN) begin
                    cfg32   <= crc32_sel;
                    cfgpass <= fcs_pass;
                end
                shreg  <= byte_n;
                bitcnt <= bitcnt + 3'd1;
                if (bitcnt == 3'd7) begin
                    if (bcnt == hold) begin
                        byte_valid <= 1'b1;
                        byte_data  <= fifo[0];
                        for (int i = 0; i < DEPTH - 1; i++) begin
                            if (CW'(i + 1) < hold)       fifo[i] <= fifo[i + 1];
                            else if (CW'(i + 1) == hold) fifo[i] <= byte_n;
                        end
                        if (hold == CW'(DEPTH)) fifo[DEPTH-1] <= byte_n;
                    end else begin
                        fifo[bcnt] <= byte_n;
                        bcnt       <= bcnt + CW'(1);
                    end
                end
            end

            if (state == ST_DATA && abort_hit) begin
                r_abort   <= 1'b1;
                r_short   <= 1'b0;
                r_crc     <= 1'b0;
                r_evshort <= 1'b0;
            end else if (state == ST_DATA && flag_hit) begin
                r_abort   <= 1'b0;
                r_short   <= end_short | end_mis;
                r_crc     <= ~end_short & ~end_mis & ~crc_ok;
                r_evshort <= end_short;
                flush_n   <= cfgpass ? bcnt : CW'(1);
            end

            if (state == ST_FLUSH) begin
                byte_valid <= 1'b1;
                byte_data  <= fifo[0];
                byte_last  <= (flush_n == CW'(1));
                flush_n    <= flush_n - CW'(1);
                for (int i = 0; i < DEPTH - 1; i++) fifo[i] <= fifo[i + 1];
            end

            if (state == ST_STAT) begin
                stat_valid   <= 1'b1;
                stat_abort   <= r_abort;
                stat_short   <= r_short;
                stat_crc_err <= r_crc;
                ev_fin       <= ~mask_fin;
                ev_short     <= r_evshort & ~mask_short;
                bcnt         <= '0;
                bitcnt       <= '0;
            end
        end
    end
endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic mask_fin,
    input logic mask_short,
    input logic mask_fill,
    input logic byte_valid,
    input logic byte_last,
    input logic stat_valid,
    input logic stat_abort,
    input logic stat_short,
    input logic stat_crc_err,
    input logic ev_fin,
    input logic ev_short,
    input logic ev_fill
);
    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && stat_valid));

    a_r12_quiet_status: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_valid |-> !(stat_abort || stat_short || stat_crc_err));

    a_r6_abort_alone: assert property (@(posedge clk) disable iff (!rst_n)
        stat_abort |-> (!stat_short && !stat_crc_err));

    a_r4_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        byte_last |-> byte_valid);

    a_r4_last_then_status: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_last) |=> stat_valid);

    a_r9_fin_with_status: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (ev_fin == !$past(mask_fin)));

    a_r9_fin_only_status: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fin |-> stat_valid);

    a_r7_short_event: assert property (@(posedge clk) disable iff (!rst_n)
        ev_short |-> (stat_valid && stat_short && !$past(mask_short)));

    a_r8_short_no_crc: assert property (@(posedge clk) disable iff (!rst_n)
        stat_short |-> !stat_crc_err);

    a_r11_fill_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fill |-> !$past(mask_fill));
endmodule

bind hdlc_rx hdlc_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mask_fin(mask_fin), .mask_short(mask_short),
    .mask_fill(mask_fill), .byte_valid(byte_valid), .byte_last(byte_last),
    .stat_valid(stat_valid), .stat_abort(stat_abort), .stat_short(stat_short),
    .stat_crc_err(stat_crc_err), .ev_fin(ev_fin), .ev_short(ev_short),
    .ev_fill(ev_fill)
);

// File: tb/hdlc_rx_bench.sv
`timescale 1ns/1ps
module hdlc_rx_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0, bit_in = 1'b1;
    logic crc32_sel = 1'b0, fcs_pass = 1'b0;
    logic mask_fin = 1'b0, mask_short = 1'b0, mask_fill = 1'b0;
    logic byte_valid, byte_last, stat_valid, stat_abort, stat_short, stat_crc_err;
    logic ev_fin, ev_short, ev_fill;
    logic [7:0] byte_data;

    always #2 clk = ~clk;

    hdlc_rx u_hdlc_rx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .crc32_sel(crc32_sel), .fcs_pass(fcs_pass), .mask_fin(mask_fin),
        .mask_short(mask_short), .mask_fill(mask_fill),
        .byte_valid(byte_valid), .byte_data(byte_data), .byte_last(byte_last),
        .stat_valid(stat_valid), .stat_abort(stat_abort), .stat_short(stat_short),
        .stat_crc_err(stat_crc_err), .ev_fin(ev_fin), .ev_short(ev_short),
        .ev_fill(ev_fill)
    );

    int checks = 0, fails = 0;
    int n_fin = 0, n_short = 0, n_fill = 0;
    int x_fin = 0, x_short = 0, x_fill = 0;
    logic [8:0] qb[$];
    string      qbr[$];
    logic [2:0] qs[$];
    string      qsr[$];
    logic [7:0] dq[$];
    int         ones_run = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: compares results against the scoreboard queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) begin
                if (qb.size() == 0) check(0, "R4", "unexpected byte", int'(byte_data), 0);
                else begin
                    logic [8:0] e;
                    string r;
                    e = qb.pop_front();
                    r = qbr.pop_front();
                    check({byte_last, byte_data} == e, r, "byte {last,data}",
                          int'({byte_last, byte_data}), int'(e));
                end
            end
            if (stat_valid) begin
                if (qs.size() == 0) check(0, "R9", "unexpected status", 0, 0);
                else begin
                    logic [2:0] e;
                    string r;
                    e = qs.pop_front();
                    r = qsr.pop_front();
                    check({stat_abort, stat_short, stat_crc_err} == e, r,
                          "status {abort,short,crc}",
                          int'({stat_abort, stat_short, stat_crc_err}), int'(e));
                end
            end
            if (ev_fin)   n_fin++;
            if (ev_short) n_short++;
            if (ev_fill)  n_fill++;
        end
    end

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b,
                                             input bit w32);
        logic fb;
        fb = c[0] ^ b;
        c  = c >> 1;
        if (fb) c = c ^ (w32 ? 32'hEDB88320 : 32'h00008408);
        return c;
    endfunction

    task automatic tx_bit(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        bit_in = b;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic tx_flag();
        tx_bit(1'b0);
        for (int i = 0; i < 6; i++) tx_bit(1'b1);
        tx_bit(1'b0);
        ones_run = 0;
    endtask

    task automatic tx_ones(input int n);
        for (int i = 0; i < n; i++) tx_bit(1'b1);
        ones_run = 0;
    endtask

    task automatic tx_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            tx_bit(v[i]);
            if (v[i]) begin
                ones_run++;
                if (ones_run == 5) begin
                    tx_bit(1'b0);
                    ones_run = 0;
                end
            end else ones_run = 0;
        end
    endtask

    // Sends payload in dq, optional FCS, extra zero bits, closing flag.
    // Pushes the expected bytes and status before sending.
    task automatic run_frame(input bit w32, input bit pass, input bit with_fcs,
                             input bit corrupt, input int extra, input string req);
        logic [31:0] c;
        logic [7:0]  fb[$];
        int nf, total;
        bit shrt, mis;
        nf = w32 ? 4 : 2;
        c  = w32 ? 32'hFFFFFFFF : 32'h0000FFFF;
        foreach (dq[k]) for (int i = 0; i < 8; i++) c = crc_step(c, dq[k][i], w32);
        c = ~c;
        if (corrupt) c = c ^ 32'h1;
        if (with_fcs) for (int k = 0; k < nf; k++) fb.push_back(c[8*k +: 8]);
        total = dq.size() + fb.size();
        shrt  = total < nf + 1;
        mis   = extra != 0;
        if (!shrt) begin
            logic [7:0] outq[$];
            outq = dq;
            if (pass) foreach (fb[k]) outq.push_back(fb[k]);
            foreach (outq[k]) begin
                qb.push_back({(k == outq.size() - 1) ? 1'b1 : 1'b0, outq[k]});
                qbr.push_back(req);
            end
        end
        qs.push_back({1'b0, shrt | mis, !shrt && !mis && corrupt});
        qsr.push_back(req);
        if (!mask_fin) x_fin++;
        if (shrt && !mask_short) x_short++;
        crc32_sel = w32;
        fcs_pass  = pass;
        foreach (dq[k]) tx_byte(dq[k]);
        foreach (fb[k]) tx_byte(fb[k]);
        for (int i = 0; i < extra; i++) tx_bit(1'b0);
        tx_flag();
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_all();
        repeat (4) @(negedge clk);
        // R12: reset state of every output
        check(!byte_valid && !byte_last && byte_data == 8'h00, "R12", "reset data outputs",
              int'({byte_valid, byte_last, byte_data}), 0);
        check(!stat_valid && !stat_abort && !stat_short && !stat_crc_err, "R12",
              "reset status outputs", int'({stat_valid, stat_abort, stat_short, stat_crc_err}), 0);
        check(!ev_fin && !ev_short && !ev_fill, "R12", "reset events",
              int'({ev_fin, ev_short, ev_fill}), 0);
        rst_n = 1'b1;
        idle(2);
        // R10: idle ones after reset give no event; first flags switch fill state
        tx_ones(10);
        tx_flag();
        x_fill++;
        tx_flag();
        idle(4);
        check(n_fill == x_fill, "R10", "fill event ones->flags", n_fill, x_fill);

        // R1 / R2: stuffing-heavy payload, CRC-16, FCS stripped
        dq = '{8'h12, 8'hFF, 8'h7E, 8'h3C};
        run_frame(1'b0, 1'b0, 1'b1, 1'b0, 0, "R1");
        // R3 / R4: CRC-32 with FCS passed on
        dq = '{8'hA5, 8'h00, 8'hFE};
        run_frame(1'b1, 1'b1, 1'b1, 1'b0, 0, "R3");
        // R4: CRC-16 with FCS passed on
        dq = '{8'h5A, 8'hF8};
        run_frame(1'b0, 1'b1, 1'b1, 1'b0, 0, "R4");
        // R5: corrupted FCS
        dq = '{8'h55, 8'h66};
        run_frame(1'b0, 1'b0, 1'b1, 1'b1, 0, "R5");
        // R7: two bytes without FCS on CRC-16 is below the minimum of three
        dq = '{8'h81, 8'h42};
        run_frame(1'b0, 1'b0, 1'b0, 1'b0, 0, "R7");
        // R2: minimum length frame, one payload byte
        dq = '{8'h9D};
        run_frame(1'b0, 1'b0, 1'b1, 1'b0, 0, "R2");
        // R3: CRC-32 minimum frame, stripped
        dq = '{8'hC3};
        run_frame(1'b1, 1'b0, 1'b1, 1'b0, 0, "R3");
        // R8: three trailing bits after the FCS
        dq = '{8'h11, 8'h22, 8'h33};
        run_frame(1'b0, 1'b0, 1'b1, 1'b0, 3, "R8");
        idle(10);
        check(n_short == x_short, "R7", "short event count", n_short, x_short);

        // R6: abort after five bytes; exactly byte 0x01 has left the buffer
        crc32_sel = 1'b0;
        fcs_pass  = 1'b0;
        qb.push_back({1'b0, 8'h01});
        qbr.push_back("R6");
        qs.push_back(3'b100);
        qsr.push_back("R6");
        x_fin++;
        tx_byte(8'h01); tx_byte(8'h02); tx_byte(8'h03); tx_byte(8'h04); tx_byte(8'h00);
        tx_ones(7);
        x_fill++;
        tx_ones(8);
        idle(10);
        check(n_fill == x_fill, "R10", "fill event flags->ones", n_fill, x_fill);
        tx_flag();
        x_fill++;
        idle(4);
        check(n_fill == x_fill, "R10", "fill event back to flags", n_fill, x_fill);

        // R11: masked events; status and data still delivered
        mask_fin   = 1'b1;
        mask_short = 1'b1;
        dq = '{8'h77};
        run_frame(1'b0, 1'b0, 1'b0, 1'b0, 0, "R11");
        dq = '{8'hE1, 8'h0F};
        run_frame(1'b0, 1'b0, 1'b1, 1'b0, 0, "R11");
        mask_fill = 1'b1;
        tx_ones(9);
        idle(10);
        check(n_fill == x_fill, "R11", "masked fill event", n_fill, x_fill);
        mask_fill = 1'b0;
        tx_flag();
        x_fill++;
        mask_fin   = 1'b0;
        mask_short = 1'b0;
        idle(20);

        check(n_fin == x_fin, "R9", "finish event count", n_fin, x_fin);
        check(n_short == x_short, "R11", "short event count after mask", n_short, x_short);
        check(n_fill == x_fill, "R10", "fill event count", n_fill, x_fill);
        check(qb.size() == 0, "R4", "bytes outstanding", qb.size(), 0);
        check(qs.size() == 0, "R9", "statuses outstanding", qs.size(), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule